// File: doc/BRIEF.md
# Bit-Serial Link Endpoint with Early Acknowledge

This block is one end of a point-to-point serial link built from a single output wire and a single input wire. Bytes handed to it over a valid/ready handshake go out as data packets. Bytes recovered from the input wire are offered to the consumer over a second valid/ready handshake. Flow control uses acknowledge packets, which share the same wires as the data in both directions. A sender keeps at most one byte in flight. It may send the next byte only after the far end has acknowledged the previous one.

The receive side sends its acknowledge as soon as it recognises an incoming data packet, provided it can be sure of room. It can be sure when both its output buffer and its overflow slot are empty at that moment. The far end can then start its next byte while the current packet is still arriving. If the output buffer is still occupied, the acknowledge is owed and is released once the byte has reached the output buffer. Every state advance happens on a cycle where `bit_en` is high, so one bit lasts one enable period. The line idles at 0.

The transmit state machine has five states:
- `TX_IDLE` drives 0.
- `TX_START` drives the 1 start bit.
- `TX_FLAG` drives the 1 data marker.
- `TX_DATA` drives the payload.
- `TX_STOP` drives 0.

`TX_IDLE` and `TX_STOP` are packet boundaries. At a boundary the machine moves to `TX_START`, or to `TX_IDLE` when there is nothing to send. From `TX_START`, an acknowledge moves to `TX_STOP` and a data packet moves to `TX_FLAG`. `TX_FLAG` moves to `TX_DATA`, and the eighth payload bit moves to `TX_STOP`.

The receive state machine has four states:
- `RX_IDLE` moves to `RX_FLAG` on a 1.
- `RX_FLAG` moves to `RX_DATA` on a 1, which marks a data packet. On a 0 it returns to `RX_IDLE`, because that bit was the stop bit of an acknowledge.
- `RX_DATA` moves to `RX_STOP` after eight bits.
- `RX_STOP` always returns to `RX_IDLE`.

Top module: `serial_link_endpoint`

## Requirements
- R1: A data packet on `link_out` is the bit sequence 1, 1, then the eight byte bits least significant first, then 0, with one bit per enable period.
- R2: An acknowledge packet on `link_out` is the two-bit sequence 1, 0.
- R3: After reset the first byte may be sent at once. A later data packet starts only after an acknowledge packet has been received since the previous data packet began.
- R4: When an acknowledge is pending at a packet boundary, it is sent before any queued byte. Packets may follow each other with no idle bit between them.
- R5: An incoming data packet is acknowledged early when its marker bit arrives while the receive buffer and the overflow slot are both empty. With the output idle, the acknowledge start bit appears three enable periods after the incoming start bit.
- R6: If the receive buffer holds a byte when a marker bit arrives, no acknowledge is sent until that byte has been taken and the new byte sits in the buffer.
- R7: Received bytes are presented in arrival order on `rx_valid`/`rx_data`. While `rx_valid` is high and `rx_ready` is low, both stay unchanged.
- R8: The transmit side holds one byte. `tx_ready` falls after an accepted byte and rises again when that byte starts its packet.
- R9: After reset `link_out` is 0, `tx_ready` is 1 and `rx_valid` is 0.
- R10: Data can flow in both directions at the same time, with acknowledges interleaved among data packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle pulse marking each bit period |
| tx_valid | input | 1 | Byte offered for sending |
| tx_data | input | DATA_W | Byte to send |
| tx_ready | output | 1 | Transmit holding slot free |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | DATA_W | Received byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| link_in | input | 1 | Serial input wire, sampled on `bit_en` |
| link_out | output | 1 | Serial output wire |

## Verification
The bench runs the input wire and records the output wire once per enable period, so it works in bit periods rather than clock cycles. A bit driven in period k is sampled by the block on the next edge. A packet that starts in period s has its stop bit in period s+10. With the output idle, the early acknowledge is due in period k+3 of the incoming start bit. A pending acknowledge follows the previous stop bit at once, in period s+11. The checks decode the recorded bit stream and compare the period in which each packet starts against these values. They wait a fixed number of bit periods before checking for an absence, and they read received bytes only after the incoming stop bit has passed.

// File: rtl/slink_pkg.sv
package slink_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_FLAG,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_FLAG,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/slink_tx.sv
module slink_tx
    import slink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              ack_pend,
    input  logic              ack_seen,
    output logic              ack_taken,
    output logic              link_out,
    output tx_state_e         state_o,
    output logic              is_ack_o,
    output logic              credit_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         st, st_nx;
    logic              is_ack, credit, full;
    logic [DATA_W-1:0] sh, hold;
    logic [CNT_W-1:0]  cnt;
    logic              start_ack, start_data;

    // next state
    always_comb begin
        st_nx      = st;
        start_ack  = 1'b0;
        start_data = 1'b0;
        if (bit_en) begin
            unique case (st)
                TX_IDLE, TX_STOP: begin
                    if (ack_pend) begin
                        st_nx     = TX_START;
                        start_ack = 1'b1;
                    end else if (full && credit) begin
                        st_nx      = TX_START;
                        start_data = 1'b1;
                    end else begin
                        st_nx = TX_IDLE;
                    end
                end
                TX_START: st_nx = is_ack ? TX_STOP : TX_FLAG;
                TX_FLAG:  st_nx = TX_DATA;
                TX_DATA:  if (cnt == CNT_W'(DATA_W - 1)) st_nx = TX_STOP;
                default:  st_nx = TX_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= TX_IDLE;
            is_ack <= 1'b0;
            credit <= 1'b1;
            full   <= 1'b0;
            sh     <= '0;
            hold   <= '0;
            cnt    <= '0;
        end else begin
            st <= st_nx;
            if (ack_seen) credit <= 1'b1;
            if (start_ack) is_ack <= 1'b1;
            if (start_data) begin
                is_ack <= 1'b0;
                sh     <= hold;
                full   <= 1'b0;
                credit <= 1'b0;
            end else if (tx_valid && !full) begin
                hold <= tx_data;
                full <= 1'b1;
            end
            if (bit_en && st == TX_FLAG) cnt <= '0;
            if (bit_en && st == TX_DATA) begin
                sh  <= sh >> 1;
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        link_out  = (st == TX_START) || (st == TX_FLAG) || ((st == TX_DATA) && sh[0]);
        tx_ready  = !full;
        ack_taken = start_ack;
        state_o   = st;
        is_ack_o  = is_ack;
        credit_o  = credit;
    end
endmodule

// File: rtl/slink_rx.sv
module slink_rx
    import slink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              link_in,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_ready,
    input  logic              ack_taken,
    output logic              ack_pend,
    output logic              ack_seen,
    output rx_state_e         state_o,
    output logic              hold_full_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         st, st_nx;
    logic [DATA_W-1:0] sh, buf_q, hold;
    logic [CNT_W-1:0]  cnt;
    logic              valid_q, hold_full, pend_q, owed;
    logic              flag_data, stop_done, take;

    // next state
    always_comb begin
        st_nx = st;
        if (bit_en) begin
            unique case (st)
                RX_IDLE: if (link_in) st_nx = RX_FLAG;
                RX_FLAG: st_nx = link_in ? RX_DATA : RX_IDLE;
                RX_DATA: if (cnt == CNT_W'(DATA_W - 1)) st_nx = RX_STOP;
                RX_STOP: st_nx = RX_IDLE;
                default: st_nx = RX_IDLE;
            endcase
        end
    end

    always_comb begin
        flag_data = bit_en && (st == RX_FLAG) && link_in;
        stop_done = bit_en && (st == RX_STOP);
        take      = valid_q && rx_ready;
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= RX_IDLE;
            sh        <= '0;
            buf_q     <= '0;
            hold      <= '0;
            cnt       <= '0;
            valid_q   <= 1'b0;
            hold_full <= 1'b0;
            pend_q    <= 1'b0;
            owed      <= 1'b0;
        end else begin
            st <= st_nx;
            if (flag_data) cnt <= '0;
            if (bit_en && st == RX_DATA) begin
                sh  <= {link_in, sh[DATA_W-1:1]};
                cnt <= cnt + 1'b1;
            end
            if (take) begin
                if (hold_full) begin
                    buf_q     <= hold;
                    hold_full <= 1'b0;
                end else begin
                    valid_q <= 1'b0;
                end
            end
            if (stop_done) begin
                if ((valid_q && !take) || hold_full) begin
                    hold      <= sh;
                    hold_full <= 1'b1;
                end else begin
                    buf_q   <= sh;
                    valid_q <= 1'b1;
                end
            end
            if (ack_taken) pend_q <= 1'b0;
            if (flag_data) begin
                if (!valid_q && !hold_full) pend_q <= 1'b1;
                else                        owed   <= 1'b1;
            end
            if (owed && st == RX_IDLE && !hold_full) begin
                owed   <= 1'b0;
                pend_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rx_valid    = valid_q;
        rx_data     = buf_q;
        ack_pend    = pend_q;
        ack_seen    = bit_en && (st == RX_FLAG) && !link_in;
        state_o     = st;
        hold_full_o = hold_full;
    end
endmodule

// File: rtl/serial_link_endpoint.sv
module serial_link_endpoint
    import slink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_ready,
    input  logic              link_in,
    output logic              link_out
);
    logic      ack_pend, ack_seen, ack_taken;
    logic      tx_is_ack, tx_credit, rx_hold_full;
    tx_state_e tx_state;
    rx_state_e rx_state;

    slink_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .ack_pend  (ack_pend),
        .ack_seen  (ack_seen),
        .ack_taken (ack_taken),
        .link_out  (link_out),
        .state_o   (tx_state),
        .is_ack_o  (tx_is_ack),
        .credit_o  (tx_credit)
    );

    slink_rx #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .link_in     (link_in),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .ack_taken   (ack_taken),
        .ack_pend    (ack_pend),
        .ack_seen    (ack_seen),
        .state_o     (rx_state),
        .hold_full_o (rx_hold_full)
    );
endmodule

// File: rtl/slink_checker.sv
module slink_checker
    import slink_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ready,
    input logic              link_in,
    input logic              link_out,
    input tx_state_e         tx_state,
    input rx_state_e         rx_state,
    input logic              tx_is_ack,
    input logic              tx_credit,
    input logic              rx_hold_full,
    input logic              ack_pend
);
    // R1: a data packet's marker bit follows its start bit
    p_marker_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && tx_state == TX_START && !tx_is_ack) |=> link_out)
        else $error("p_marker_high_r1");

    // R3: a byte leaves the holding slot only while credit is held
    p_credit_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(tx_credit))
        else $error("p_credit_gate_r3");

    // R4: a pending acknowledge wins the packet boundary
    p_ack_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && ack_pend && (tx_state == TX_IDLE || tx_state == TX_STOP))
        |=> (tx_state == TX_START && tx_is_ack))
        else $error("p_ack_first_r4");

    // R5: free buffers at the marker bit give an immediate acknowledge
    p_early_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && rx_state == RX_FLAG && link_in && !rx_valid && !rx_hold_full)
        |=> ack_pend)
        else $error("p_early_ack_r5");

    // R6: no data packet arrives while the overflow slot is occupied
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && rx_state == RX_FLAG && link_in) |-> !rx_hold_full)
        else $error("p_no_overflow_r6");

    // R7: an untaken byte stays put
    p_rx_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)))
        else $error("p_rx_stable_r7");

    // R8: the holding slot closes once a byte is accepted
    p_tx_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready)
        else $error("p_tx_accept_r8");
endmodule

bind serial_link_endpoint slink_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_ready     (rx_ready),
    .link_in      (link_in),
    .link_out     (link_out),
    .tx_state     (tx_state),
    .rx_state     (rx_state),
    .tx_is_ack    (tx_is_ack),
    .tx_credit    (tx_credit),
    .rx_hold_full (rx_hold_full),
    .ack_pend     (ack_pend)
);

// File: tb/tb_serial_link_endpoint.sv
module tb_serial_link_endpoint;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_ready = 1'b0;
    logic       link_in = 1'b0;
    logic       link_out;

    serial_link_endpoint #(.DATA_W(8)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .link_in  (link_in),
        .link_out (link_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    int   tick_n = 0;
    bit   out_log[$];
    bit   in_q[$];
    int   dec_pos = 0;
    int   bad_stop = 0;
    bit   pk_ack[$];
    int   pk_val[$];
    int   pk_at[$];

    // bit-period generator: records link_out and drives link_in once per period
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div++;
            if (div == DIV) begin
                div = 0;
                bit_en = 1'b1;
                out_log.push_back(link_out);
                link_in = (in_q.size() > 0) ? in_q.pop_front() : 1'b0;
                tick_n++;
            end else begin
                bit_en = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int t = tick_n + n;
        while (tick_n < t) @(posedge clk);
    endtask

    task automatic send_tx(input logic [7:0] b);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = b;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic read_rx(output logic [7:0] b);
        @(negedge clk);
        while (!rx_valid) @(negedge clk);
        b = rx_data;
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic push_frame(input logic [7:0] b);
        in_q.push_back(1'b1);
        in_q.push_back(1'b1);
        for (int i = 0; i < 8; i++) in_q.push_back(b[i]);
        in_q.push_back(1'b0);
    endtask

    task automatic push_ack();
        in_q.push_back(1'b1);
        in_q.push_back(1'b0);
    endtask

    // decode complete packets from the recorded output bits
    task automatic decode();
        forever begin
            if (dec_pos >= out_log.size()) break;
            if (!out_log[dec_pos]) begin
                dec_pos++;
            end else begin
                if (dec_pos + 1 >= out_log.size()) break;
                if (!out_log[dec_pos + 1]) begin
                    pk_ack.push_back(1'b1);
                    pk_val.push_back(0);
                    pk_at.push_back(dec_pos);
                    dec_pos += 2;
                end else begin
                    int v = 0;
                    if (dec_pos + 10 >= out_log.size()) break;
                    for (int i = 0; i < 8; i++) v |= int'(out_log[dec_pos + 2 + i]) << i;
                    if (out_log[dec_pos + 10]) bad_stop++;
                    pk_ack.push_back(1'b0);
                    pk_val.push_back(v);
                    pk_at.push_back(dec_pos);
                    dec_pos += 11;
                end
            end
        end
    endtask

    function automatic int expect_ack_at(input int incoming_start);
        return incoming_start + 3;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        logic [7:0] got;
        int base, k0, s;
        void'($urandom(32'd2718));

        repeat (6) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(link_out == 1'b0, "R9", "link_out after reset", link_out, 0);
        chk(tx_ready == 1'b1, "R9", "tx_ready after reset", tx_ready, 1);
        chk(rx_valid == 1'b0, "R9", "rx_valid after reset", rx_valid, 0);

        // R1: first byte goes out at once with the data packet layout
        wait_ticks(2);
        decode();
        base = pk_at.size();
        send_tx(8'hA5);
        wait_ticks(16);
        decode();
        chk(pk_at.size() == base + 1, "R1", "packets for first byte", pk_at.size() - base, 1);
        if (pk_at.size() > base) begin
            chk(!pk_ack[base], "R1", "first packet kind is data", pk_ack[base], 0);
            chk(pk_val[base] == 8'hA5, "R1", "first byte value", pk_val[base], 8'hA5);
        end

        // R3 and R8: next byte waits in the slot until an acknowledge arrives
        base = pk_at.size();
        send_tx(8'h3C);
        wait_ticks(30);
        decode();
        chk(tx_ready == 1'b0, "R8", "slot held while unacknowledged", tx_ready, 0);
        chk(pk_at.size() == base, "R3", "no packet without acknowledge", pk_at.size() - base, 0);
        push_ack();
        wait_ticks(16);
        decode();
        chk(pk_at.size() == base + 1, "R3", "packet after acknowledge", pk_at.size() - base, 1);
        if (pk_at.size() > base)
            chk(!pk_ack[base] && pk_val[base] == 8'h3C, "R3", "second byte value", pk_val[base], 8'h3C);
        chk(tx_ready == 1'b1, "R8", "slot free after send", tx_ready, 1);

        // R5 and R2: early acknowledge with empty buffers
        base = pk_at.size();
        k0 = out_log.size();
        push_frame(8'h5E);
        wait_ticks(16);
        decode();
        chk(pk_at.size() == base + 1, "R2", "one acknowledge packet", pk_at.size() - base, 1);
        if (pk_at.size() > base) begin
            chk(pk_ack[base], "R2", "packet is 1,0 acknowledge", pk_ack[base], 1);
            chk(pk_at[base] == expect_ack_at(k0), "R5", "early acknowledge period",
                pk_at[base], expect_ack_at(k0));
            chk(pk_at[base] < k0 + 10, "R5", "ack before incoming stop bit", pk_at[base], k0 + 10);
        end
        chk(rx_valid && rx_data == 8'h5E, "R7", "received byte presented", rx_data, 8'h5E);

        // R6: buffer occupied at the marker bit, acknowledge withheld
        base = pk_at.size();
        push_frame(8'h71);
        wait_ticks(30);
        decode();
        chk(pk_at.size() == base, "R6", "acknowledge withheld", pk_at.size() - base, 0);
        chk(rx_data == 8'h5E, "R7", "untaken byte held", rx_data, 8'h5E);
        read_rx(got);
        chk(got == 8'h5E, "R7", "first received byte", got, 8'h5E);
        wait_ticks(8);
        decode();
        chk(pk_at.size() == base + 1 && pk_ack[pk_at.size() - 1], "R6",
            "acknowledge after byte taken", pk_at.size() - base, 1);
        read_rx(got);
        chk(got == 8'h71, "R7", "second received byte in order", got, 8'h71);

        // R4: pending acknowledge beats a queued byte at the boundary
        push_ack();
        wait_ticks(6);
        decode();
        base = pk_at.size();
        send_tx(8'h11);
        push_ack();
        push_frame(8'h22);
        send_tx(8'h33);
        wait_ticks(30);
        decode();
        chk(pk_at.size() == base + 3, "R4", "three packets", pk_at.size() - base, 3);
        if (pk_at.size() >= base + 3) begin
            s = pk_at[base];
            chk(!pk_ack[base] && pk_val[base] == 8'h11, "R4", "first is byte 11", pk_val[base], 8'h11);
            chk(pk_ack[base + 1] && pk_at[base + 1] == s + 11, "R4",
                "ack right after stop", pk_at[base + 1], s + 11);
            chk(!pk_ack[base + 2] && pk_val[base + 2] == 8'h33 && pk_at[base + 2] == s + 13, "R4",
                "queued byte after ack", pk_at[base + 2], s + 13);
        end
        read_rx(got);
        chk(got == 8'h22, "R7", "byte received during send", got, 8'h22);

        // R10: random bytes in both directions at once
        push_ack();
        wait_ticks(6);
        for (int it = 0; it < 10; it++) begin
            logic [7:0] bi, bo;
            int n_ack, n_dat, dval;
            bi = 8'($urandom);
            bo = 8'($urandom);
            decode();
            base = pk_at.size();
            wait_ticks(int'($urandom_range(0, 5)));
            push_frame(bi);
            send_tx(bo);
            wait_ticks(40);
            decode();
            n_ack = 0;
            n_dat = 0;
            dval = -1;
            for (int j = base; j < pk_at.size(); j++) begin
                if (pk_ack[j]) n_ack++;
                else begin n_dat++; dval = pk_val[j]; end
            end
            chk(n_ack == 1, "R10", "acknowledges in round", n_ack, 1);
            chk(n_dat == 1 && dval == int'(bo), "R10", "sent byte in round", dval, int'(bo));
            read_rx(got);
            chk(got == bi, "R10", "received byte in round", got, bi);
            push_ack();
            wait_ticks(4);
        end

        chk(bad_stop == 0, "R1", "stop bits low", bad_stop, 0);
        finish_run();
    end
endmodule